// File: doc/BRIEF.md
# Lane-Crossing Outcome Rule Machine

This block decides what happens to the player's frog in a lane-crossing game after each screen refresh. At the end of each frame a set of colour-class flags arrives. Some describe the background under the frog's footprint: all green, all blue, all black, or some black. Others describe the moving objects under the footprint: something non-black, something brown, something green. The frog's row index arrives alongside the flags. From these the machine tracks whether the frog stands on grass, on the road or on the river. It declares a death when a vehicle or open water is underneath, and a win when a green goal object is reached in the top row.

A death or a win is latched into an outcome state. The matching flag then stays high for a programmable number of clock cycles. After that the machine drops the flag, gives a one-cycle request to put the frog back at its start position, and returns to grass. The log-riding output is combinational from the current state and the live brown-object flag, so the motion logic can carry the frog along with a log within the same cycle.

Top module: `frog_rule_fsm`

## Requirements
- R1: A synchronous active-high `rst` puts the machine on grass with `dead`, `win`, `on_log` and `frog_reset` all low at the next clock edge. This holds even in the middle of an outcome hold.
- R2: Colour and row inputs are acted on only in a cycle where `frame_end` is high. Without it, no terrain change or outcome occurs.
- R3: On a sample, the new terrain is chosen by this priority: all-green gives grass, then all-blue gives river, then all-black gives road, then some-black gives road. With none of these flags, the current terrain is kept.
- R4: If the sampled terrain is road and an object pixel is non-black, the next cycle shows `dead` high.
- R5: If the sampled terrain is river and no object pixel is brown, the next cycle shows `dead` high.
- R6: `on_log` is high exactly when the current state is river and `obj_any_brown` is high. This holds in any cycle, whether or not a sample is taken.
- R7: A sample with a green object while `row` equals 0 and no death condition makes `win` high in the next cycle. A non-zero row gives no win.
- R8: When a death and a win condition arrive in the same sample, death is chosen. `dead` and `win` are never high together.
- R9: After entering an outcome, its flag stays high for exactly HOLD_CYCLES cycles. The next cycle has the flag low and `frog_reset` high for one cycle. After that the machine is on grass with all outputs low.
- R10: While an outcome is held, samples are ignored: a new death or win condition neither restarts nor changes the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_end | input | 1 | Strobe marking a valid colour sample |
| bg_any_black | input | 1 | Some background pixel under the frog is black |
| bg_all_black | input | 1 | Every background pixel under the frog is black |
| bg_all_green | input | 1 | Every background pixel under the frog is green |
| bg_all_blue | input | 1 | Every background pixel under the frog is blue |
| obj_any_nonblack | input | 1 | Some object pixel under the frog is non-black |
| obj_any_brown | input | 1 | Some object pixel under the frog is brown (log) |
| obj_any_green | input | 1 | Some object pixel under the frog is green (goal) |
| row | input | ROW_W | Frog row index, 0 is the goal row |
| dead | output | 1 | Death outcome being held |
| win | output | 1 | Win outcome being held |
| on_log | output | 1 | Frog is riding a log on the river |
| frog_reset | output | 1 | One-cycle request to return the frog to start |

## Verification
The main sweep starts the machine on each of grass, road and river. From each start it applies all 128 combinations of the seven colour flags with the row at 0 and at 1. This separates classification priority, hazard detection per terrain, goal detection per row and death-over-win priority. When a sample leaves the frog alive, two follow-up probes identify the terrain it was left on: a live brown flag with no sample, and a mixed-footprint sample with a non-black object. Directed runs measure the exact hold length of both outcomes and confirm that samples are ignored during a hold. They also confirm that colour changes without a strobe have no effect and that reset clears a hold in mid-count.

// File: rtl/frog_rules_pkg.sv
package frog_rules_pkg;

    typedef enum logic [2:0] {
        ST_GRASS = 3'd0,
        ST_ROAD  = 3'd1,
        ST_RIVER = 3'd2,
        ST_DEAD  = 3'd3,
        ST_WIN   = 3'd4
    } rule_state_e;

    typedef struct packed {
        logic bg_any_black;
        logic bg_all_black;
        logic bg_all_green;
        logic bg_all_blue;
        logic obj_any_nonblack;
        logic obj_any_brown;
        logic obj_any_green;
    } colour_sample_t;

    function automatic logic is_alive(rule_state_e st);
        return (st == ST_GRASS) || (st == ST_ROAD) || (st == ST_RIVER);
    endfunction

    function automatic logic is_outcome(rule_state_e st);
        return (st == ST_DEAD) || (st == ST_WIN);
    endfunction

    // Terrain priority: grass, river, road, partial road, otherwise keep.
    function automatic rule_state_e pick_terrain(colour_sample_t s, rule_state_e cur);
        rule_state_e t;
        if (s.bg_all_green)      t = ST_GRASS;
        else if (s.bg_all_blue)  t = ST_RIVER;
        else if (s.bg_all_black) t = ST_ROAD;
        else if (s.bg_any_black) t = ST_ROAD;
        else                     t = cur;
        return t;
    endfunction

endpackage

// File: rtl/sample_judge.sv
module sample_judge
    import frog_rules_pkg::*;
#(
    parameter int ROW_W = 4
) (
    input  colour_sample_t      sample,
    input  rule_state_e         cur_state,
    input  logic [ROW_W-1:0]    row,
    output rule_state_e         terrain,
    output logic                hit_death,
    output logic                hit_win
);
    localparam logic [ROW_W-1:0] GOAL_ROW = '0;

    logic road_hazard;
    logic water_hazard;

    always_comb begin
        terrain      = pick_terrain(sample, cur_state);
        road_hazard  = (terrain == ST_ROAD)  && sample.obj_any_nonblack;
        water_hazard = (terrain == ST_RIVER) && !sample.obj_any_brown;
        hit_death    = road_hazard || water_hazard;
        // R8: death wins over goal
        hit_win      = sample.obj_any_green && (row == GOAL_ROW) && !hit_death;
    end

    always_comb begin
        assert_judge_excl_R8: assert (!(hit_death && hit_win));
    end

endmodule

// File: rtl/outcome_timer.sv
module outcome_timer #(
    parameter int HOLD_CYCLES = 75_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_CYCLES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LIMIT);

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT);

    assert_cnt_restart_R9: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

endmodule

// File: rtl/frog_rule_fsm.sv
module frog_rule_fsm
    import frog_rules_pkg::*;
#(
    parameter int ROW_W       = 4,
    parameter int HOLD_CYCLES = 75_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_end,
    input  logic             bg_any_black,
    input  logic             bg_all_black,
    input  logic             bg_all_green,
    input  logic             bg_all_blue,
    input  logic             obj_any_nonblack,
    input  logic             obj_any_brown,
    input  logic             obj_any_green,
    input  logic [ROW_W-1:0] row,
    output logic             dead,
    output logic             win,
    output logic             on_log,
    output logic             frog_reset
);
    colour_sample_t sample;
    rule_state_e    state, state_nx, terrain;
    logic           hit_death, hit_win;
    logic           hold_run, hold_done;

    assign sample = '{bg_any_black:     bg_any_black,
                      bg_all_black:     bg_all_black,
                      bg_all_green:     bg_all_green,
                      bg_all_blue:      bg_all_blue,
                      obj_any_nonblack: obj_any_nonblack,
                      obj_any_brown:    obj_any_brown,
                      obj_any_green:    obj_any_green};

    sample_judge #(.ROW_W(ROW_W)) u_judge (
        .sample    (sample),
        .cur_state (state),
        .row       (row),
        .terrain   (terrain),
        .hit_death (hit_death),
        .hit_win   (hit_win)
    );

    assign hold_run = is_outcome(state);

    outcome_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (hold_run),
        .expired (hold_done)
    );

    always_comb begin
        state_nx = state;
        if (is_alive(state)) begin
            if (frame_end) begin
                if (hit_death)    state_nx = ST_DEAD;
                else if (hit_win) state_nx = ST_WIN;
                else              state_nx = terrain;
            end
        end else if (hold_done) begin
            state_nx = ST_GRASS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_GRASS;
        else     state <= state_nx;
    end

    // Mealy outputs
    assign dead       = (state == ST_DEAD) && !hold_done;
    assign win        = (state == ST_WIN)  && !hold_done;
    assign frog_reset = hold_run && hold_done;
    assign on_log     = (state == ST_RIVER) && obj_any_brown;

    assert_outputs_excl_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dead, win, frog_reset}));

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!dead && !win && !frog_reset && state == ST_GRASS));

    assert_needs_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        (is_alive(state) && !frame_end) |=> $stable(state));

    assert_death_taken_R4: assert property (@(posedge clk) disable iff (rst)
        (is_alive(state) && frame_end && hit_death) |=> dead);

    assert_log_only_river_R6: assert property (@(posedge clk) disable iff (rst)
        on_log |-> (state == ST_RIVER));

    assert_reset_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        frog_reset |=> (!frog_reset && !dead && !win && state == ST_GRASS));

    assert_hold_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (is_outcome(state) && !hold_done) |=> $stable(state));

endmodule

// File: tb/tb_frog_rule_fsm.sv
module tb_frog_rule_fsm;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W      = 4;
    localparam int HOLD       = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_end = 1'b0;
    logic bg_any_black = 1'b0, bg_all_black = 1'b0, bg_all_green = 1'b0, bg_all_blue = 1'b0;
    logic obj_any_nonblack = 1'b0, obj_any_brown = 1'b0, obj_any_green = 1'b0;
    logic [ROW_W-1:0] row = '0;
    logic dead, win, on_log, frog_reset;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frog_rule_fsm #(.ROW_W(ROW_W), .HOLD_CYCLES(HOLD)) dut (
        .clk(clk), .rst(rst), .frame_end(frame_end),
        .bg_any_black(bg_any_black), .bg_all_black(bg_all_black),
        .bg_all_green(bg_all_green), .bg_all_blue(bg_all_blue),
        .obj_any_nonblack(obj_any_nonblack), .obj_any_brown(obj_any_brown),
        .obj_any_green(obj_any_green), .row(row),
        .dead(dead), .win(win), .on_log(on_log), .frog_reset(frog_reset)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // bits: {any_black, all_black, all_green, all_blue, nonblack, brown, green}
    task automatic put(input logic [6:0] b, input logic fe, input int r);
        {bg_any_black, bg_all_black, bg_all_green, bg_all_blue,
         obj_any_nonblack, obj_any_brown, obj_any_green} = b;
        frame_end = fe;
        row = ROW_W'(r);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; put(7'b0, 1'b0, 1);
        @(negedge clk); rst = 1'b0;
    endtask

    // terrain codes in bench: 0 grass, 1 road, 2 river
    task automatic go_terrain(input int t);
        @(negedge clk);
        case (t)
            0: put(7'b0010000, 1'b1, 1);
            1: put(7'b1100000, 1'b1, 1);
            default: put(7'b0001010, 1'b1, 1);
        endcase
    endtask

    function automatic int model_terrain(input logic [6:0] b, input int cur);
        if (b[4]) return 0;
        if (b[3]) return 2;
        if (b[5]) return 1;
        if (b[6]) return 1;
        return cur;
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        do_reset();
        // R1: reset state
        #1;
        chk("R1 dead", dead, 1'b0);
        chk("R1 win", win, 1'b0);
        chk("R1 on_log", on_log, 1'b0);
        chk("R1 frog_reset", frog_reset, 1'b0);

        // Sweep: every start terrain, every flag pattern, goal and non-goal row
        for (int s = 0; s < 3; s++) begin
            for (int r = 0; r < 2; r++) begin
                for (int p = 0; p < 128; p++) begin
                    logic [6:0] b;
                    int  t;
                    logic exp_dead, exp_win;
                    b = 7'(p);
                    t = model_terrain(b, s);
                    exp_dead = (t == 1 && b[2]) || (t == 2 && !b[1]);
                    exp_win  = b[0] && (r == 0) && !exp_dead;
                    do_reset();
                    go_terrain(s);
                    @(negedge clk);
                    put(b, 1'b1, r);
                    #1;
                    chk("R6 on_log before sample", on_log, (s == 2) && b[1]);
                    @(negedge clk);
                    put(7'b0, 1'b0, 1);
                    #1;
                    chk("R3/R4/R5/R8 dead", dead, exp_dead);
                    chk("R7/R8 win", win, exp_win);
                    if (!exp_dead && !exp_win) begin
                        put(7'b0000010, 1'b0, 1);
                        #1;
                        chk("R3 river probe via R6", on_log, t == 2);
                        @(negedge clk);
                        put(7'b0000100, 1'b1, 1);
                        @(negedge clk);
                        put(7'b0, 1'b0, 1);
                        #1;
                        chk("R3 kept terrain probe", dead, t != 0);
                    end
                end
            end
        end

        // R2: colour changes without the strobe are ignored
        do_reset();
        @(negedge clk);
        put(7'b1100100, 1'b0, 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            #1;
            chk("R2 no strobe dead", dead, 1'b0);
        end
        put(7'b0000101, 1'b0, 0);
        @(negedge clk);
        #1;
        chk("R2 no strobe win", win, 1'b0);
        put(7'b0000100, 1'b1, 1);
        @(negedge clk);
        put(7'b0, 1'b0, 1);
        #1;
        chk("R2 still on grass", dead, 1'b0);

        // R9/R10: death hold length, samples ignored during hold
        do_reset();
        go_terrain(1);
        @(negedge clk);
        put(7'b1100100, 1'b1, 1);
        for (int k = 0; k < HOLD; k++) begin
            @(negedge clk);
            put(7'b0010001, 1'b1, 0);
            #1;
            chk("R9 dead held", dead, 1'b1);
            chk("R10 win ignored", win, 1'b0);
            chk("R9 no early reset", frog_reset, 1'b0);
        end
        @(negedge clk);
        put(7'b0, 1'b0, 1);
        #1;
        chk("R9 dead drops", dead, 1'b0);
        chk("R9 reset pulse", frog_reset, 1'b1);
        @(negedge clk);
        #1;
        chk("R9 pulse single", frog_reset, 1'b0);
        chk("R9 back dead", dead, 1'b0);
        chk("R9 back win", win, 1'b0);

        // R9/R10: win hold length
        do_reset();
        @(negedge clk);
        put(7'b0010001, 1'b1, 0);
        for (int k = 0; k < HOLD; k++) begin
            @(negedge clk);
            put(7'b1100100, 1'b1, 1);
            #1;
            chk("R9 win held", win, 1'b1);
            chk("R10 death ignored", dead, 1'b0);
        end
        @(negedge clk);
        put(7'b0, 1'b0, 1);
        #1;
        chk("R9 win drops", win, 1'b0);
        chk("R9 win reset pulse", frog_reset, 1'b1);
        @(negedge clk);
        #1;
        chk("R9 after win", frog_reset | win | dead, 1'b0);

        // R1: reset in mid-hold
        do_reset();
        go_terrain(2);
        @(negedge clk);
        put(7'b0001000, 1'b1, 1);
        @(negedge clk);
        put(7'b0, 1'b0, 1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 mid-hold dead", dead, 1'b0);
        chk("R1 mid-hold reset pulse", frog_reset, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule